// File: doc/BRIEF.md
# USB Low/Full-Speed Line Event Decoder

This block watches the two data lines of a low-speed or full-speed USB link, sampled once per clock, and turns them into a stream of single-cycle events. Each sample pair is sorted into one of four line states. A J-to-K transition while the line is idle marks the start of a packet. Bit timing is then recovered from a fixed number of samples per bit. The block samples each bit in its middle, undoes the NRZI coding, strips stuff bits and recognises the end of the packet.

A downstream packet parser uses the outputs. There is one strobe each for start of packet, data bit (with its value), stuff bit and end of packet. A symbol strobe carries the raw line state seen at every bit sample point. One sample clock serves both speeds. A low-speed bit lasts eight times as many samples as a full-speed bit, and the `low_speed_i` pin selects the speed. That pin is expected to change only while the line is idle.

Top module: `usb_line_decoder`

## Requirements
- R1: At full speed, a sample with dp high and dm low is J, dp low and dm high is K, both low is SE0 and both high is SE1. These are reported on `sym_o` as J=0, K=1, SE0=2, SE1=3.
- R2: With `low_speed_i`=1, the J and K line levels swap relative to full speed. SE0 and SE1 are unchanged, and a bit lasts 8×`FS_SPB` samples.
- R3: While idle, a K sample that directly follows a J sample raises `sop_o` for one cycle, one cycle after the K sample. A K that follows any other sample starts nothing.
- R4: The first bit sample point is the sample half a bit period (bit period/2 samples) after the SOP sample. Each later sample point follows the previous one by one bit period. Every sample point raises `sym_valid_o` with that symbol on `sym_o`, one cycle later.
- R5: NRZI decoding gives 1 when the sampled symbol equals the symbol at the previous sample point and 0 when it differs. The previous symbol is J at the start of each packet and is updated at every sample point.
- R6: A decoded 0 that arrives while the ones count is exactly 6 is a stuff bit. It raises `stuff_o`, not `bit_valid_o`, and clears the count. A decoded 1 raises the count, saturating at 7, and a data 0 clears it. A 0 after seven ones is data.
- R7: SE0 and SE1 sample points produce no data or stuff strobe. An SE0 moves the decoder into its end-of-packet state.
- R8: In the end-of-packet state, a J sample point directly after an SE0 sample point raises `eop_o` together with `sym_valid_o`. The decoder then returns to idle, ready for the next SOP.
- R9: During and right after reset, every strobe output is low.
- R10: At most one of `sop_o`, `bit_valid_o`, `stuff_o` and `eop_o` is high in any cycle, and each is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one line sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| low_speed_i | input | 1 | 1 selects low-speed polarity and bit period |
| dp_i | input | 1 | Sampled D+ line |
| dm_i | input | 1 | Sampled D- line |
| sop_o | output | 1 | Start-of-packet strobe |
| sym_valid_o | output | 1 | Strobe at each bit sample point |
| sym_o | output | 2 | Symbol at the sample point (J=0, K=1, SE0=2, SE1=3) |
| bit_valid_o | output | 1 | Data bit strobe |
| bit_o | output | 1 | Decoded data bit value |
| stuff_o | output | 1 | Stuff bit strobe |
| eop_o | output | 1 | End-of-packet strobe |

## Verification
The bench builds the block with `FS_SPB`=4, the smallest allowed ratio. That gives a two-sample half-bit at full speed and a 32-sample low-speed bit, so both speeds fit in short runs. At this ratio the half-bit offset and the full-bit spacing after SOP differ, so a misplaced sample point shows up as a wrong gap between strobes. The packets cover a stuff bit after six ones, a data 0 after seven ones, an SE1 inside a packet, a one-SE0 end of packet and a two-SE0 end of packet. The bench also drives a K that follows SE0 while idle, which must start nothing.

// File: rtl/usbld_pkg.sv
package usbld_pkg;
  typedef enum logic [1:0] {
    SYM_J   = 2'd0,
    SYM_K   = 2'd1,
    SYM_SE0 = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_END  = 2'd2
  } dec_state_e;

  localparam int unsigned LS_RATE_DIV = 8;  // full-speed / low-speed bit rate
  localparam int unsigned STUFF_RUN   = 6;
endpackage

// File: rtl/usbld_classify.sv
module usbld_classify
  import usbld_pkg::*;
(
  input  logic      dp_i,
  input  logic      dm_i,
  input  logic      low_speed_i,
  output line_sym_e sym_o
);
  always_comb begin
    case ({dp_i, dm_i})
      2'b00:   sym_o = SYM_SE0;
      2'b11:   sym_o = SYM_SE1;
      2'b10:   sym_o = low_speed_i ? SYM_K : SYM_J;
      default: sym_o = low_speed_i ? SYM_J : SYM_K;
    endcase
  end
endmodule

// File: rtl/usbld_bit_timer.sv
module usbld_bit_timer
  import usbld_pkg::*;
#(
  parameter int unsigned FS_SPB = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_speed_i,
  input  logic start_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned LS_SPB = FS_SPB * LS_RATE_DIV;
  localparam int unsigned CNT_W  = $clog2(LS_SPB);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_m1;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    period_m1 = low_speed_i ? CNT_W'(LS_SPB - 1)     : CNT_W'(FS_SPB - 1);
    half_m1   = low_speed_i ? CNT_W'(LS_SPB / 2 - 1) : CNT_W'(FS_SPB / 2 - 1);
  end

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= half_m1;  // first sample point lands mid-bit
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? period_m1 : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/usbld_frame_fsm.sv
module usbld_frame_fsm
  import usbld_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_sym_e sym_i,
  input  logic      tick_i,
  output logic      start_o,
  output logic      run_o,
  output logic      sop_o,
  output logic      sym_valid_o,
  output line_sym_e sym_o,
  output logic      bit_valid_o,
  output logic      bit_o,
  output logic      stuff_o,
  output logic      eop_o
);
  localparam int unsigned ONES_W = $clog2(STUFF_RUN + 2);

  dec_state_e state_q, state_d;
  line_sym_e  prev_q, prev_d;
  line_sym_e  last_q;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic sop_d, symv_d, bitv_d, bit_d, stuff_d, eop_d;
  logic same_sym;

  assign start_o  = (state_q == ST_IDLE) && (last_q == SYM_J) && (sym_i == SYM_K);
  assign run_o    = (state_q != ST_IDLE);
  assign same_sym = (sym_i == prev_q);

  always_comb begin
    state_d = state_q;
    prev_d  = prev_q;
    ones_d  = ones_q;
    sop_d   = 1'b0;
    symv_d  = 1'b0;
    bitv_d  = 1'b0;
    bit_d   = 1'b0;
    stuff_d = 1'b0;
    eop_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        prev_d = SYM_J;
        ones_d = '0;
        if (start_o) begin
          state_d = ST_DATA;
          sop_d   = 1'b1;
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          symv_d = 1'b1;
          prev_d = sym_i;
          case (sym_i)
            SYM_SE0: state_d = ST_END;
            SYM_SE1: ;
            default: begin
              if (!same_sym && ones_q == ONES_W'(STUFF_RUN)) begin
                stuff_d = 1'b1;
                ones_d  = '0;
              end else begin
                bitv_d = 1'b1;
                bit_d  = same_sym;
                if (!same_sym)         ones_d = '0;
                else if (ones_q != '1) ones_d = ones_q + 1'b1;
              end
            end
          endcase
        end
      end
      ST_END: begin
        if (tick_i) begin
          symv_d = 1'b1;
          prev_d = sym_i;
          if (sym_i == SYM_J && prev_q == SYM_SE0) begin
            eop_d   = 1'b1;
            state_d = ST_IDLE;
            ones_d  = '0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      prev_q      <= SYM_J;
      last_q      <= SYM_J;
      ones_q      <= '0;
      sop_o       <= 1'b0;
      sym_valid_o <= 1'b0;
      sym_o       <= SYM_J;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      stuff_o     <= 1'b0;
      eop_o       <= 1'b0;
    end else begin
      state_q     <= state_d;
      prev_q      <= prev_d;
      last_q      <= sym_i;
      ones_q      <= ones_d;
      sop_o       <= sop_d;
      sym_valid_o <= symv_d;
      if (symv_d) sym_o <= sym_i;
      bit_valid_o <= bitv_d;
      bit_o       <= bit_d;
      stuff_o     <= stuff_d;
      eop_o       <= eop_d;
    end
  end
endmodule

// File: rtl/usb_line_decoder.sv
module usb_line_decoder
  import usbld_pkg::*;
#(
  parameter int unsigned FS_SPB = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       low_speed_i,
  input  logic       dp_i,
  input  logic       dm_i,
  output logic       sop_o,
  output logic       sym_valid_o,
  output logic [1:0] sym_o,
  output logic       bit_valid_o,
  output logic       bit_o,
  output logic       stuff_o,
  output logic       eop_o
);
  line_sym_e line_sym;
  line_sym_e sym_out;
  logic      start, run, tick;

  usbld_classify u_classify (
    .dp_i        (dp_i),
    .dm_i        (dm_i),
    .low_speed_i (low_speed_i),
    .sym_o       (line_sym)
  );

  usbld_bit_timer #(.FS_SPB(FS_SPB)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .low_speed_i (low_speed_i),
    .start_i     (start),
    .run_i       (run),
    .tick_o      (tick)
  );

  usbld_frame_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_i       (line_sym),
    .tick_i      (tick),
    .start_o     (start),
    .run_o       (run),
    .sop_o       (sop_o),
    .sym_valid_o (sym_valid_o),
    .sym_o       (sym_out),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .stuff_o     (stuff_o),
    .eop_o       (eop_o)
  );

  assign sym_o = sym_out;
endmodule

// File: rtl/usbld_checks.sv
module usbld_checks (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sop_o,
  input logic       sym_valid_o,
  input logic [1:0] sym_o,
  input logic       bit_valid_o,
  input logic       stuff_o,
  input logic       eop_o
);
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sop_o, bit_valid_o, stuff_o, eop_o}));

  a_r7_bit_on_jk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o || stuff_o) |-> (sym_valid_o && sym_o[1] == 1'b0));

  a_r8_eop_on_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (sym_valid_o && sym_o == 2'd0));

  a_r4_no_sample_after_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |=> !sym_valid_o);

  a_r10_sop_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |=> !sop_o);

  a_r10_eop_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);

  a_r6_stuff_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_o |=> !stuff_o);
endmodule

bind usb_line_decoder usbld_checks u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sop_o       (sop_o),
  .sym_valid_o (sym_valid_o),
  .sym_o       (sym_o),
  .bit_valid_o (bit_valid_o),
  .stuff_o     (stuff_o),
  .eop_o       (eop_o)
);

// File: tb/sim_usb_line_decoder.sv
module sim_usb_line_decoder;
  localparam int FS = 4;
  localparam int LS = FS * 8;
  localparam int SJ = 0, SK = 1, S0 = 2, S1 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic low = 1'b0;
  logic dp = 1'b1;
  logic dm = 1'b0;
  logic sop, symv, bitv, bitval, stuff, eop;
  logic [1:0] sym;

  int n_cmp = 0;
  int n_bad = 0;
  int n_unexp = 0;
  int gap_cnt = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  int         gap_q[$];
  string      tag_q[$];
  bit         spd_q[$];

  always #2 clk = ~clk;

  usb_line_decoder #(.FS_SPB(FS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .low_speed_i(low), .dp_i(dp), .dm_i(dm),
    .sop_o(sop), .sym_valid_o(symv), .sym_o(sym), .bit_valid_o(bitv),
    .bit_o(bitval), .stuff_o(stuff), .eop_o(eop)
  );

  function automatic logic [1:0] enc(int s, logic ls);
    case (s)
      SJ:      enc = ls ? 2'b01 : 2'b10;
      SK:      enc = ls ? 2'b10 : 2'b01;
      S0:      enc = 2'b00;
      default: enc = 2'b11;
    endcase
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver: model the expected event stream, queue it, then drive the line.
  task automatic send(input int s[$]);
    int spb, prev, ones;
    bit first, ending, done;
    logic [7:0] w;
    string t;
    spb = low ? LS : FS;
    prev = SJ; ones = 0; first = 1; ending = 0; done = 0;
    exp_q.push_back(8'b1000_0000); gap_q.push_back(-1);
    tag_q.push_back("R3"); spd_q.push_back(low);
    foreach (s[i]) begin
      if (!done) begin
        bit one;
        w = 8'b0; w[6] = 1'b1; w[5:4] = 2'(s[i]); t = "R4";
        if (!ending) begin
          if (s[i] == S0) begin ending = 1; t = "R7"; end
          else if (s[i] == S1) t = "R7";
          else begin
            one = (s[i] == prev);
            if (!one && ones == 6) begin w[1] = 1'b1; ones = 0; t = "R6"; end
            else begin
              w[3] = 1'b1; w[2] = one; t = "R5";
              ones = one ? ((ones < 7) ? ones + 1 : 7) : 0;
            end
          end
        end else if (s[i] == SJ && prev == S0) begin
          w[0] = 1'b1; done = 1; t = "R8";
        end
        prev = s[i];
        exp_q.push_back(w); gap_q.push_back(first ? spb / 2 : spb);
        tag_q.push_back(t); spd_q.push_back(low);
        first = 0;
      end
    end
    foreach (s[i]) begin
      {dp, dm} = enc(s[i], low);
      repeat (spb) @(negedge clk);
    end
    {dp, dm} = enc(SJ, low);
    repeat (2 * spb) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      gap_cnt++;
      if (sop || symv || bitv || stuff || eop) begin
        logic [7:0] w;
        w = {sop, symv, sym, bitv, bitv & bitval, stuff, eop};
        n_cmp++;
        if ($countones({sop, bitv, stuff, eop}) > 1) begin
          n_bad++;
          $display("FAIL R10: strobes %b, expected at most one", {sop, bitv, stuff, eop});
        end
        if (exp_q.size() == 0) begin
          n_bad++; n_unexp++;
          $display("FAIL R3: unexpected event %b, expected none", w);
        end else begin
          logic [7:0] e; int g; string t; bit ls;
          e = exp_q.pop_front(); g = gap_q.pop_front();
          t = tag_q.pop_front(); ls = spd_q.pop_front();
          n_cmp++;
          if (w[5:4] != e[5:4]) begin
            n_bad++;
            $display("FAIL %s: sym %0d, expected %0d", ls ? "R2" : "R1", w[5:4], e[5:4]);
          end
          n_cmp++;
          if ({w[7:6], w[3:0]} != {e[7:6], e[3:0]}) begin
            n_bad++;
            $display("FAIL %s: event %b, expected %b", t, w, e);
          end
          if (g >= 0) begin
            n_cmp++;
            if (gap_cnt != g) begin
              n_bad++;
              $display("FAIL R4: gap %0d cycles, expected %0d", gap_cnt, g);
            end
          end
        end
        gap_cnt = 0;
      end
    end
  end

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run incomplete, expected finish");
    finished = 1'b1;
    summary();
  end

  initial begin
    int pa[$], pc[$], pd[$];
    pa = '{SK, SJ, SK, SJ, SK, SJ, SK, SK, SK, SK, SK, SK, SK, SJ, SJ, SK, S0, S0, SJ};
    pc = '{SK, SJ, SK, SK, S1, SJ, SK, S0, SJ};
    pd = '{SK, SJ, SK, SK, SK, SK, SK, SK, SK, SK, SJ, SK, S0, SJ};

    repeat (3) @(negedge clk);
    n_cmp++;
    if ({sop, symv, bitv, stuff, eop} != 5'b0) begin
      n_bad++;
      $display("FAIL R9: strobes %b in reset, expected 00000", {sop, symv, bitv, stuff, eop});
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if ({sop, symv, bitv, stuff, eop} != 5'b0) begin
      n_bad++;
      $display("FAIL R9: strobes %b after reset, expected 00000", {sop, symv, bitv, stuff, eop});
    end
    repeat (4) @(negedge clk);

    send(pa);                       // R6 stuff after six ones, R8 two-SE0 end
    send(pc);                       // R7 SE1 inside packet, one-SE0 end
    send(pd);                       // R6 data 0 after seven ones

    // R3: K after SE0 while idle must not start a packet
    {dp, dm} = enc(S0, low); repeat (4) @(negedge clk);
    {dp, dm} = enc(SK, low); repeat (4) @(negedge clk);
    {dp, dm} = enc(SJ, low); repeat (8) @(negedge clk);
    n_cmp++;
    if (n_unexp != 0 || exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3: %0d unexpected events, expected 0", n_unexp);
    end

    low = 1'b1;                     // R2 low-speed polarity and period
    {dp, dm} = enc(SJ, low); repeat (8) @(negedge clk);
    send(pa);
    send(pd);
    low = 1'b0;
    {dp, dm} = enc(SJ, low); repeat (8) @(negedge clk);
    send(pc);

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8: %0d events missing, expected 0", exp_q.size());
    end
    finished = 1'b1;
    summary();
  end
endmodule